// File: doc/BRIEF.md
# Data Access Permission Checker and Fault Encoder

This block sits after address translation in a load/store pipeline. For each data access it takes the access direction, the privilege of the requester, the effective address and the access length. It also takes the hit indication and flag word of the leaf translation for the page that holds the first byte. A second hit and flag word describes the page after it. The block decides in a single clock whether the access may complete.

A permitted load raises the register writeback enable for one cycle, and a permitted store raises the memory write enable for one cycle. A refused access raises neither enable. Instead it pulses a fault strobe and records a fault status word and a fault address in two registers. Those registers keep their values until the next fault or until a clear request.

The flags are checked and never updated. A leaf whose reference or change bit is not set is treated as a fault, so software can set the bit and retry. An access whose bytes run past the end of its page is also checked against the following page. If only the following page refuses the access, the recorded address is the base of that page.

Top module: `perm_fault_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, loadWbEn, storeEn and faultPulse are 0, and faultStatus and faultAddr are 0.
- R2: Flag word bits are: 0 execute, 1 write, 2 read, 3 privileged-only, 5 non-cacheable, 7 change, 8 reference. A load accepted with a hit, read set and reference set raises loadWbEn for exactly the cycle after the request. A store with a hit, write set, reference set and change set raises storeEn for that cycle instead.
- R3: A request whose page has no translation gives faultStatus 0x40000000 for a load and 0x42000000 for a store. Every store fault code has bit 25 (0x02000000) set, and no load fault code has it.
- R4: A hit page lacking the needed permission gives 0x08000000 for a load and 0x0A000000 for a store. A load needs read and a store needs write.
- R5: An access made with reqUser=1 to a page with the privileged-only flag set is a permission fault with the R4 codes.
- R6: A hit, permitted page whose reference bit is clear, or (for a store) whose change bit is clear, gives 0x00040000 for a load and 0x02040000 for a store.
- R7: When several causes apply, only the highest-ranked one is reported. Missing translation ranks above permission, and permission ranks above reference/change.
- R8: A faulting request pulses faultPulse in the cycle after it and raises neither loadWbEn nor storeEn.
- R9: On a fault found in the first page, faultAddr holds the request's effective address.
- R10: Pages are 4096 bytes. When reqAddr's page offset plus reqLen (1 to 8) exceeds 4096, the next page is also checked. If only that page faults, its cause is recorded with faultAddr equal to its base address. A first-page fault takes precedence. When the access does not cross, the second page's inputs have no effect.
- R11: faultStatus and faultAddr change only on a fault or on clearFault. clearFault zeroes both. A fault in the same cycle as clearFault is recorded.
- R12: The execute and non-cacheable flags have no effect on the outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Access request this cycle |
| reqStore | input | 1 | 1 = store, 0 = load |
| reqUser | input | 1 | Requester runs unprivileged |
| reqAddr | input | 32 | Effective address of first byte |
| reqLen | input | 4 | Access length in bytes, 1 to 8 |
| lowHit | input | 1 | Translation exists for the first page |
| lowFlags | input | 9 | Leaf flags of the first page |
| highHit | input | 1 | Translation exists for the next page |
| highFlags | input | 9 | Leaf flags of the next page |
| clearFault | input | 1 | Zero the fault status and address |
| loadWbEn | output | 1 | Load may write its destination register |
| storeEn | output | 1 | Store may update memory |
| faultPulse | output | 1 | Request was refused |
| faultStatus | output | 32 | Latched fault cause word |
| faultAddr | output | 32 | Latched fault address |

## Verification
The hardest case to reach from the ports is a page-crossing access where the first page is fully permitted and only the second page refuses. Most addresses and lengths never cross, so the stimulus places the address a few bytes below a page boundary with an 8-byte length. The bench then varies the second page's hit and flags on their own. Its counterpart, an access ending exactly on the boundary with a hostile second page, shows that the second page is ignored when the access does not cross. A full sweep over direction, privilege, hit and the five deciding flag bits, with the two neutral flags toggled alongside, covers every priority combination.

// File: rtl/perm_fault_pkg.sv
package perm_fault_pkg;

  localparam int FLAG_W       = 9;
  localparam int STATUS_W     = 32;
  localparam int FL_EXEC      = 0;
  localparam int FL_WRITE     = 1;
  localparam int FL_READ      = 2;
  localparam int FL_PRIV      = 3;
  localparam int FL_NOCACHE   = 5;
  localparam int FL_CHANGE    = 7;
  localparam int FL_REF       = 8;

  localparam logic [STATUS_W-1:0] CODE_NOXLATE = 32'h4000_0000;
  localparam logic [STATUS_W-1:0] CODE_PERM    = 32'h0800_0000;
  localparam logic [STATUS_W-1:0] CODE_RC      = 32'h0004_0000;
  localparam logic [STATUS_W-1:0] CODE_STORE   = 32'h0200_0000;

  typedef struct packed {
    logic capture;
    logic clear;
    logic grantLoad;
    logic grantStore;
  } ctlStrobes_t;

  // Ranked cause for one page; zero means the page allows the access.
  function automatic logic [STATUS_W-1:0] rankCause(
      input logic hit, input logic [FLAG_W-1:0] flags,
      input logic isStore, input logic isUser);
    logic [STATUS_W-1:0] dirBit;
    logic permOk, rcOk;
    dirBit = isStore ? CODE_STORE : '0;
    permOk = (isStore ? flags[FL_WRITE] : flags[FL_READ]) &&
             !(isUser && flags[FL_PRIV]);
    rcOk   = flags[FL_REF] && (!isStore || flags[FL_CHANGE]);
    if (!hit)         return CODE_NOXLATE | dirBit;
    else if (!permOk) return CODE_PERM | dirBit;
    else if (!rcOk)   return CODE_RC | dirBit;
    else              return '0;
  endfunction

endpackage

// File: rtl/perm_fault_dp.sv
module perm_fault_dp
  import perm_fault_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  parameter int LEN_W     = 4,
  parameter int NUM_PAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqStore,
  input  logic                  reqUser,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic [LEN_W-1:0]      reqLen,
  input  logic [NUM_PAGES-1:0]  pageHit,
  input  logic [FLAG_W-1:0]     pageFlags [NUM_PAGES],
  input  ctlStrobes_t           strobes,
  output logic                  faultAny,
  output logic [STATUS_W-1:0]   faultStatus,
  output logic [ADDR_W-1:0]     faultAddr
);

  localparam int SPAN_W = PAGE_BITS + 1;
  localparam logic [SPAN_W-1:0] PAGE_LIMIT = SPAN_W'(1) << PAGE_BITS;

  logic [SPAN_W-1:0]   spanEnd;
  logic                crossing;
  logic [ADDR_W-1:0]   nextBase;
  logic [STATUS_W-1:0] pageCause [NUM_PAGES];
  logic [STATUS_W-1:0] selCause;
  logic [ADDR_W-1:0]   selAddr;

  assign spanEnd  = {1'b0, reqAddr[PAGE_BITS-1:0]} + SPAN_W'(reqLen);
  assign crossing = spanEnd > PAGE_LIMIT;
  assign nextBase = {reqAddr[ADDR_W-1:PAGE_BITS] + 1'b1, {PAGE_BITS{1'b0}}};

  for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
    logic inSpan;
    assign inSpan = (p == 0) ? 1'b1 : crossing;
    assign pageCause[p] = inSpan ?
        rankCause(pageHit[p], pageFlags[p], reqStore, reqUser) : '0;
  end

  always_comb begin
    selCause = '0;
    selAddr  = '0;
    for (int p = NUM_PAGES - 1; p >= 0; p--) begin
      if (pageCause[p] != '0) begin
        selCause = pageCause[p];
        selAddr  = (p == 0) ? reqAddr : nextBase;
      end
    end
  end

  assign faultAny = selCause != '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      faultStatus <= '0;
      faultAddr   <= '0;
    end else if (strobes.capture) begin
      faultStatus <= selCause;
      faultAddr   <= selAddr;
    end else if (strobes.clear) begin
      faultStatus <= '0;
      faultAddr   <= '0;
    end
  end

  p_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture && !strobes.clear |=> $stable(faultStatus) && $stable(faultAddr));

  p_clear_r11: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clear && !strobes.capture |=> faultStatus == '0 && faultAddr == '0);

endmodule

// File: rtl/perm_fault_ctl.sv
module perm_fault_ctl
  import perm_fault_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqStore,
  input  logic        faultAny,
  input  logic        clearFault,
  output ctlStrobes_t strobes,
  output logic        loadWbEn,
  output logic        storeEn,
  output logic        faultPulse
);

  always_comb begin
    strobes.capture    = reqValid && faultAny;
    strobes.clear      = clearFault;
    strobes.grantLoad  = reqValid && !faultAny && !reqStore;
    strobes.grantStore = reqValid && !faultAny && reqStore;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadWbEn   <= 1'b0;
      storeEn    <= 1'b0;
      faultPulse <= 1'b0;
    end else begin
      loadWbEn   <= strobes.grantLoad;
      storeEn    <= strobes.grantStore;
      faultPulse <= strobes.capture;
    end
  end

  p_no_commit_r8: assert property (@(posedge clk) disable iff (!rstN)
    faultPulse |-> !loadWbEn && !storeEn);

  p_one_grant_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({loadWbEn, storeEn, faultPulse}));

endmodule

// File: rtl/perm_fault_unit.sv
module perm_fault_unit
  import perm_fault_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  parameter int LEN_W     = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic                reqStore,
  input  logic                reqUser,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [LEN_W-1:0]    reqLen,
  input  logic                lowHit,
  input  logic [FLAG_W-1:0]   lowFlags,
  input  logic                highHit,
  input  logic [FLAG_W-1:0]   highFlags,
  input  logic                clearFault,
  output logic                loadWbEn,
  output logic                storeEn,
  output logic                faultPulse,
  output logic [STATUS_W-1:0] faultStatus,
  output logic [ADDR_W-1:0]   faultAddr
);

  localparam int NUM_PAGES = 2;

  ctlStrobes_t           strobes;
  logic                  faultAny;
  logic [NUM_PAGES-1:0]  pageHit;
  logic [FLAG_W-1:0]     pageFlags [NUM_PAGES];

  assign pageHit      = {highHit, lowHit};
  assign pageFlags[0] = lowFlags;
  assign pageFlags[1] = highFlags;

  perm_fault_dp #(
    .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .LEN_W(LEN_W), .NUM_PAGES(NUM_PAGES)
  ) dp_i (
    .clk(clk), .rstN(rstN), .reqStore(reqStore), .reqUser(reqUser),
    .reqAddr(reqAddr), .reqLen(reqLen), .pageHit(pageHit),
    .pageFlags(pageFlags), .strobes(strobes), .faultAny(faultAny),
    .faultStatus(faultStatus), .faultAddr(faultAddr)
  );

  perm_fault_ctl ctl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqStore(reqStore),
    .faultAny(faultAny), .clearFault(clearFault), .strobes(strobes),
    .loadWbEn(loadWbEn), .storeEn(storeEn), .faultPulse(faultPulse)
  );

  p_code_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    faultPulse |-> faultStatus != '0);

  p_store_dir_r3: assert property (@(posedge clk) disable iff (!rstN)
    faultPulse |-> faultStatus[25] == $past(reqStore));

endmodule

// File: tb/perm_fault_unit_tb.sv
module perm_fault_unit_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqStore = 1'b0, reqUser = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [3:0]  reqLen = 4'd8;
  logic        lowHit = 1'b0, highHit = 1'b0, clearFault = 1'b0;
  logic [8:0]  lowFlags = '0, highFlags = '0;
  logic        loadWbEn, storeEn, faultPulse;
  logic [31:0] faultStatus, faultAddr;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] expStatus = '0, expAddr = '0;

  always #5 clk = ~clk;

  perm_fault_unit dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqStore(reqStore),
    .reqUser(reqUser), .reqAddr(reqAddr), .reqLen(reqLen),
    .lowHit(lowHit), .lowFlags(lowFlags), .highHit(highHit),
    .highFlags(highFlags), .clearFault(clearFault), .loadWbEn(loadWbEn),
    .storeEn(storeEn), .faultPulse(faultPulse), .faultStatus(faultStatus),
    .faultAddr(faultAddr)
  );

  function automatic logic [31:0] expCause(bit hit, logic [8:0] f, bit st, bit usr);
    logic [31:0] dir = st ? 32'h0200_0000 : 32'h0;
    if (!hit) return 32'h4000_0000 | dir;
    if ((st ? !f[1] : !f[2]) || (usr && f[3])) return 32'h0800_0000 | dir;
    if (!f[8] || (st && !f[7])) return 32'h0004_0000 | dir;
    return 32'h0;
  endfunction

  function automatic string causeTag(bit hit, logic [8:0] f, bit st, bit usr);
    if (!hit) return (f[2] | f[1]) ? "R3/R8/R9" : "R3/R7/R8/R9";
    if (usr && f[3] && (st ? f[1] : f[2])) return "R5/R8/R9";
    if (st ? !f[1] : !f[2]) return (f[8] && (!st || f[7])) ? "R4/R8/R9" : "R4/R7/R8/R9";
    if (!f[8] || (st && !f[7])) return "R6/R8/R9";
    return "R2/R12";
  endfunction

  task automatic check(string tag, logic [66:0] act, logic [66:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual wb=%0b st=%0b flt=%0b status=%h addr=%h expected wb=%0b st=%0b flt=%0b status=%h addr=%h",
               tag, act[66], act[65], act[64], act[63:32], act[31:0],
               exp[66], exp[65], exp[64], exp[63:32], exp[31:0]);
    end
  endtask

  task automatic doReq(bit v, bit st, bit usr, logic [31:0] a, logic [3:0] ln,
                       bit h0, logic [8:0] f0, bit h1, logic [8:0] f1, bit clr, string tag);
    logic [31:0] c0, c1, code, fa;
    bit crosses;
    @(negedge clk);
    reqValid = v; reqStore = st; reqUser = usr; reqAddr = a; reqLen = ln;
    lowHit = h0; lowFlags = f0; highHit = h1; highFlags = f1; clearFault = clr;
    @(negedge clk);
    reqValid = 1'b0; clearFault = 1'b0;
    crosses = ({20'b0, a[11:0]} + {28'b0, ln}) > 32'd4096;
    c0 = expCause(h0, f0, st, usr);
    c1 = crosses ? expCause(h1, f1, st, usr) : 32'h0;
    code = 32'h0; fa = 32'h0;
    if (v && c0 != 0) begin code = c0; fa = a; end
    else if (v && c1 != 0) begin code = c1; fa = (a & 32'hFFFF_F000) + 32'h1000; end
    if (code != 0) begin expStatus = code; expAddr = fa; end
    else if (clr) begin expStatus = 0; expAddr = 0; end
    check(tag, {loadWbEn, storeEn, faultPulse, faultStatus, faultAddr},
          {v && code == 0 && !st, v && code == 0 && st, code != 0, expStatus, expAddr});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [8:0] ok = 9'h186;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset", {loadWbEn, storeEn, faultPulse, faultStatus, faultAddr}, 67'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after reset", {loadWbEn, storeEn, faultPulse, faultStatus, faultAddr}, 67'h0);

    // Sweep direction, privilege, hit and the five deciding flag bits.
    for (int st = 0; st < 2; st++)
      for (int usr = 0; usr < 2; usr++)
        for (int h = 0; h < 2; h++)
          for (int m = 0; m < 32; m++) begin
            logic [8:0] f = '0;
            f[2] = m[0]; f[1] = m[1]; f[3] = m[2]; f[7] = m[3]; f[8] = m[4];
            f[0] = m[0] ^ h[0]; f[5] = st[0] ^ m[1];
            doReq(1, st[0], usr[0], 32'h0012_4000 + 32'(m * 8), 4'd8,
                  h[0], f, 1'b0, 9'h0, 1'b0, causeTag(h[0], f, st[0], usr[0]));
          end

    // Page crossing.
    doReq(1, 0, 0, 32'h0039_FFFD, 4'd8, 1, ok, 0, 9'h0, 0, "R10 load crosses into unmapped");
    doReq(1, 1, 0, 32'h0039_FFFD, 4'd8, 1, ok, 0, 9'h0, 0, "R10 store crosses into unmapped");
    doReq(1, 1, 0, 32'h0039_FFFD, 4'd8, 1, ok, 1, 9'h104, 0, "R10 store second page no write");
    doReq(1, 0, 1, 32'h0039_FFFF, 4'd2, 1, ok, 1, 9'h10C, 0, "R10 R5 second page privileged");
    doReq(1, 0, 0, 32'h0039_FFFD, 4'd8, 1, 9'h104, 1, 9'h004, 0, "R10 R6 second page no ref");
    doReq(1, 0, 0, 32'h0039_FFF9, 4'd8, 1, 9'h004, 0, 9'h0, 0, "R10 first page wins");
    doReq(1, 0, 0, 32'h0039_FFF8, 4'd8, 1, ok, 0, 9'h0, 0, "R10 ends on boundary, no cross");
    doReq(1, 1, 0, 32'h0039_FFFC, 4'd4, 1, ok, 0, 9'h0, 0, "R10 store ends on boundary");
    doReq(1, 1, 0, 32'h0039_FFFD, 4'd8, 1, ok, 1, ok, 0, "R10 crossing both pages ok");

    // Hold, clear, and clear colliding with a fault.
    doReq(1, 0, 0, 32'h0012_3000, 4'd8, 0, 9'h0, 0, 9'h0, 0, "R3 load miss");
    doReq(1, 0, 0, 32'h0012_4000, 4'd8, 1, ok, 0, 9'h0, 0, "R11 grant keeps status");
    doReq(0, 1, 0, 32'h0055_5000, 4'd8, 0, 9'h0, 0, 9'h0, 0, "R11 idle keeps status");
    doReq(0, 0, 0, 32'h0, 4'd8, 0, 9'h0, 0, 9'h0, 1, "R11 clear zeroes");
    doReq(1, 1, 0, 32'h0014_9168, 4'd8, 0, 9'h0, 0, 9'h0, 1, "R11 fault wins over clear");
    doReq(1, 0, 0, 32'h0014_9000, 4'd8, 1, ok, 0, 9'h0, 1, "R11 grant with clear");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule